// File: doc/BRIEF.md
# Phase-Frequency Detector with Turbo Acquisition Control

This block is the digital core of a synthesizer loop's phase comparator. It watches two divided clock streams, one from the reference divider and one from the oscillator divider, all sampled on a fast system clock. A rising edge on either stream sets a pending flag for that side. When both flags are set, both clear on the next clock. The result is a three-state output: source, sink or idle. A sense-polarity input picks which lead direction sources current. This lets the block serve oscillators whose frequency rises with tune voltage as well as those whose frequency falls.

Alongside the pump enables, the block produces a 2-bit magnitude code and the nominal pump current in microamps. The code comes from one of two programmed sets, chosen by the same select that picks the divider set. A lock detector counts comparisons whose error pulse is shorter than a programmable window. While turbo is enabled and armed, the block asks for a large acquisition current. Turbo disarms by itself once lock is reported. It re-arms when the set select changes or when the enable sees a new rising edge.

Top module: `pfd_turbo_top`

## Requirements
- R1: While reset is held, both pump enables and the lock flag are low, and turbo is armed, so the turbo output equals the turbo-enable input.
- R2: A rising edge on one divided input alone sets that side's pending state on the next clock. It stays set until the other input rises. Both states are then high for exactly one clock and return to idle on the clock after.
- R3: With the polarity input at 1, a reference-first comparison drives the source enable and an oscillator-first comparison drives the sink enable. With polarity at 0 the two enables swap.
- R4: Rising edges on both inputs in the same clock give one clock with both enables high and no lone phase.
- R5: The source and sink enables are never both high on two consecutive clocks.
- R6: The error width of a comparison is the number of clocks that exactly one side was pending. A comparison passes when this width is smaller than the window input. The lock flag rises on the clock after the 16th consecutive passing comparison.
- R7: When a lone pending phase reaches the window length, the lock flag is low from the next clock on, and the pass count restarts from zero.
- R8: The magnitude code output is set A's code when the set select is 1 and set B's code when it is 0.
- R9: With turbo off, the current output maps code 00 to 150, 01 to 210, 10 to 300 and 11 to 425 (microamps).
- R10: The turbo output is the turbo enable ANDed with an armed state. While it is high the current output is 2100. The armed state clears one clock after the lock flag is seen high.
- R11: A change of the set select, or a rising edge of the turbo enable, re-arms turbo and clears the pass count. The lock flag is low on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_div | input | 1 | Divided reference clock stream |
| osc_div | input | 1 | Divided oscillator clock stream |
| pol | input | 1 | Sense polarity: 1 sources on reference lead |
| turbo_en | input | 1 | Turbo acquisition enable |
| set_sel | input | 1 | 1 selects set A, 0 selects set B |
| code_a | input | 2 | Programmed magnitude code, set A |
| code_b | input | 2 | Programmed magnitude code, set B |
| lock_win | input | 8 | Lock window in clocks |
| pump_src | output | 1 | Charge-pump source enable |
| pump_snk | output | 1 | Charge-pump sink enable |
| pump_code | output | 2 | Selected programmed magnitude code |
| cp_ua | output | 12 | Nominal pump current in microamps |
| locked | output | 1 | Lock indication |
| turbo_on | output | 1 | Turbo acquisition active |

## Verification
The bench sweeps both polarities, both lead orders and error widths from coincident edges to past the window. This catches a detector that leaves both enables high for longer than one clock, one that swaps the polarity sense, or one that emits a lone pulse on coincident edges. Widths one below and at the window probe an off-by-one in the pass test: a faulty design would lock on a pulse that should fail, or would never reach lock. The bench drives a long wide pulse while locked and checks that the flag drops mid-pulse rather than waiting for the pulse to end. It toggles the select and the enable after lock, so a design that fails to re-arm would keep reporting lock with the small current. A full sweep of codes over both sets exposes a swapped set mux or a wrong current mapping.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  localparam int UA_W = 12;

  // nominal post-acquisition current for a magnitude code
  function automatic logic [UA_W-1:0] code_to_ua(input logic [1:0] code);
    logic [UA_W-1:0] ua;
    case (code)
      2'b00:   ua = UA_W'(150);
      2'b01:   ua = UA_W'(210);
      2'b10:   ua = UA_W'(300);
      default: ua = UA_W'(425);
    endcase
    return ua;
  endfunction

  // pass test for one comparison: width strictly below window
  function automatic logic width_passes(input logic [7:0] width,
                                        input logic [7:0] win);
    return width < win;
  endfunction

endpackage

// File: rtl/pfd_edge_core.sv
module pfd_edge_core (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic osc_in,
  output logic up,
  output logic dn
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw_in;
  logic [NCH-1:0] rise;

  assign raw_in = {osc_in, ref_in};

  for (genvar g = 0; g < NCH; g++) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk) begin
      prev_q <= raw_in[g];
    end
    assign rise[g] = raw_in[g] & ~prev_q;
  end

  // three-state flops: both set -> joint clear one clock later
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (up && dn) begin
      up <= rise[0];
      dn <= rise[1];
    end else begin
      up <= up | rise[0];
      dn <= dn | rise[1];
    end
  end

endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int WIN_W  = 8,
  parameter int LOCK_N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up,
  input  logic             dn,
  input  logic [WIN_W-1:0] win,
  input  logic             restart,
  output logic             locked,
  output logic             cmp_ok,
  output logic             win_hit
);
  import pfd_pkg::*;

  localparam int CNT_W = $clog2(LOCK_N + 1);
  localparam logic [WIN_W-1:0] WMAX = '1;

  logic [WIN_W-1:0] wcnt;
  logic [CNT_W-1:0] good;
  logic             lone;
  logic             cmp_done;

  assign lone     = up ^ dn;
  assign cmp_done = up & dn;
  assign cmp_ok   = cmp_done & width_passes(8'(wcnt), 8'(win));
  assign win_hit  = lone & (({1'b0, wcnt} + 1'b1) >= {1'b0, win});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
    end else if (cmp_done) begin
      wcnt <= '0;
    end else if (lone && wcnt != WMAX) begin
      wcnt <= wcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      good <= '0;
    end else if (restart || win_hit) begin
      good <= '0;
    end else if (cmp_done) begin
      if (cmp_ok) begin
        if (good != CNT_W'(LOCK_N)) good <= good + 1'b1;
      end else begin
        good <= '0;
      end
    end
  end

  assign locked = (good == CNT_W'(LOCK_N));

endmodule

// File: rtl/pfd_turbo_ctl.sv
module pfd_turbo_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       turbo_en,
  input  logic       set_sel,
  input  logic       locked,
  input  logic [1:0] code_a,
  input  logic [1:0] code_b,
  output logic       turbo_on,
  output logic       rearm,
  output logic [1:0] pump_code
);
  logic sel_q;
  logic en_q;
  logic armed;

  always_ff @(posedge clk) begin
    sel_q <= set_sel;
    en_q  <= turbo_en;
  end

  assign rearm = rst_n & ((set_sel != sel_q) | (turbo_en & ~en_q));

  always_ff @(posedge clk) begin
    if (!rst_n)      armed <= 1'b1;
    else if (rearm)  armed <= 1'b1;
    else if (locked) armed <= 1'b0;
  end

  assign turbo_on  = turbo_en & armed;
  assign pump_code = set_sel ? code_a : code_b;

endmodule

// File: rtl/pfd_turbo_top.sv
module pfd_turbo_top #(
  parameter int WIN_W    = 8,
  parameter int LOCK_N   = 16,
  parameter int TURBO_UA = 2100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_div,
  input  logic             osc_div,
  input  logic             pol,
  input  logic             turbo_en,
  input  logic             set_sel,
  input  logic [1:0]       code_a,
  input  logic [1:0]       code_b,
  input  logic [WIN_W-1:0] lock_win,
  output logic             pump_src,
  output logic             pump_snk,
  output logic [1:0]       pump_code,
  output logic [11:0]      cp_ua,
  output logic             locked,
  output logic             turbo_on
);
  import pfd_pkg::*;

  logic up, dn;
  logic cmp_ok, win_hit, rearm;

  pfd_edge_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_in (ref_div),
    .osc_in (osc_div),
    .up     (up),
    .dn     (dn)
  );

  pfd_lock_det #(.WIN_W(WIN_W), .LOCK_N(LOCK_N)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .up      (up),
    .dn      (dn),
    .win     (lock_win),
    .restart (rearm),
    .locked  (locked),
    .cmp_ok  (cmp_ok),
    .win_hit (win_hit)
  );

  pfd_turbo_ctl u_turbo (
    .clk       (clk),
    .rst_n     (rst_n),
    .turbo_en  (turbo_en),
    .set_sel   (set_sel),
    .locked    (locked),
    .code_a    (code_a),
    .code_b    (code_b),
    .turbo_on  (turbo_on),
    .rearm     (rearm),
    .pump_code (pump_code)
  );

  // reference lead (up) sources when pol=1
  assign pump_src = pol ? up : dn;
  assign pump_snk = pol ? dn : up;
  assign cp_ua    = turbo_on ? UA_W'(TURBO_UA) : code_to_ua(pump_code);

endmodule

// File: rtl/pfd_turbo_chk.sv
module pfd_turbo_chk #(
  parameter int TURBO_UA = 2100
) (
  input logic        clk,
  input logic        rst_n,
  input logic        set_sel,
  input logic        pump_src,
  input logic        pump_snk,
  input logic        locked,
  input logic        turbo_on,
  input logic [11:0] cp_ua,
  input logic        cmp_ok,
  input logic        win_hit
);

  a_r5_overlap_single: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_src && pump_snk) |=> !(pump_src && pump_snk));

  a_r2_lone_src_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_src && !pump_snk) |=> pump_src);

  a_r2_lone_snk_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_snk && !pump_src) |=> pump_snk);

  a_r6_lock_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(cmp_ok));

  a_r7_window_drops: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |=> !locked);

  a_r10_turbo_current: assert property (@(posedge clk) disable iff (!rst_n)
    turbo_on |-> cp_ua == 12'(TURBO_UA));

  a_r10_turbo_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && turbo_on) |=> (!turbo_on || !locked));

  a_r11_sel_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(set_sel) |=> !locked);

endmodule

bind pfd_turbo_top pfd_turbo_chk #(.TURBO_UA(TURBO_UA)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .set_sel  (set_sel),
  .pump_src (pump_src),
  .pump_snk (pump_snk),
  .locked   (locked),
  .turbo_on (turbo_on),
  .cp_ua    (cp_ua),
  .cmp_ok   (cmp_ok),
  .win_hit  (win_hit)
);

// File: tb/test_pfd_turbo_top.sv
module test_pfd_turbo_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK_N     = 16;
  localparam int TURBO_UA   = 2100;
  localparam int UA_TAB[4]  = '{150, 210, 300, 425};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_div = 1'b0, osc_div = 1'b0, pol = 1'b1;
  logic        turbo_en = 1'b1, set_sel = 1'b1;
  logic [1:0]  code_a = 2'b10, code_b = 2'b01;
  logic [7:0]  lock_win = 8'd4;
  logic        pump_src, pump_snk, locked, turbo_on;
  logic [1:0]  pump_code;
  logic [11:0] cp_ua;

  int total = 0, bad = 0;
  int good = 0;
  bit armed = 1'b1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_turbo_top i_pfd_turbo_top (
    .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .osc_div(osc_div),
    .pol(pol), .turbo_en(turbo_en), .set_sel(set_sel),
    .code_a(code_a), .code_b(code_b), .lock_win(lock_win),
    .pump_src(pump_src), .pump_snk(pump_snk), .pump_code(pump_code),
    .cp_ua(cp_ua), .locked(locked), .turbo_on(turbo_on)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_ua();
    if (turbo_en && armed) return TURBO_UA;
    return UA_TAB[set_sel ? code_a : code_b];
  endfunction

  // one comparison: lead input rises, the other d clocks later
  task automatic compare(input int d, input bit ref_first);
    int lone_exp;
    lone_exp = (ref_first == pol) ? 2 : 1;   // {src,snk}
    if (d == 0) begin ref_div = 1'b1; osc_div = 1'b1; end
    else if (ref_first) ref_div = 1'b1;
    else osc_div = 1'b1;
    for (int i = 1; i <= d + 3; i++) begin
      @(posedge clk); @(negedge clk);
      if (i <= d)          chk("R2/R3 lone phase", {pump_src, pump_snk}, lone_exp);
      else if (i == d + 1) chk("R2/R4 joint phase", {pump_src, pump_snk}, 3);
      else                 chk("R2 idle after clear", {pump_src, pump_snk}, 0);
      if (d >= lock_win && i == lock_win + 1)
        chk("R7 lock dropped mid-pulse", locked, 0);
      if (i == d) begin ref_div = 1'b1; osc_div = 1'b1; end
    end
    ref_div = 1'b0; osc_div = 1'b0;
    if (d < lock_win) begin if (good < LOCK_N) good++; end
    else good = 0;
    @(posedge clk); @(negedge clk);
    if (good == LOCK_N) armed = 1'b0;
    chk("R6 lock flag", locked, good == LOCK_N);
    chk("R10 turbo flag", turbo_on, turbo_en && armed);
    chk("R10/R9 current", cp_ua, exp_ua());
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset enables", {pump_src, pump_snk}, 0);
    chk("R1 reset lock", locked, 0);
    chk("R1 reset turbo", turbo_on, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // polarity x lead x width sweep around window 4
    for (int p = 0; p < 2; p++) begin
      pol = p[0];
      for (int lead = 0; lead < 2; lead++)
        for (int d = 0; d <= 5; d++) compare(d, lead[0]);
    end

    // acquire: widths 3 (= win-1) pass, reach lock, turbo releases
    for (int k = 0; k < LOCK_N; k++) compare((k % 2) ? 3 : 1, k[0]);
    chk("R6 locked after 16 passes", locked, 1);
    chk("R10 turbo released", turbo_on, 0);

    // select change re-arms
    set_sel = 1'b0;
    @(posedge clk); @(negedge clk);
    good = 0; armed = 1'b1;
    chk("R11 select change unlocks", locked, 0);
    chk("R11 select change rearms", turbo_on, 1);
    chk("R8 code follows set B", pump_code, code_b);

    for (int k = 0; k < LOCK_N; k++) compare(2, 1'b1);
    chk("R6 relock", locked, 1);
    compare(6, 1'b0);   // wide pulse drops lock (R7)
    for (int k = 0; k < LOCK_N; k++) compare(0, 1'b1);

    // enable toggle re-arms
    turbo_en = 1'b0;
    @(negedge clk);
    chk("R10 turbo off with enable low", turbo_on, 0);
    chk("R9 programmed current", cp_ua, UA_TAB[code_b]);
    turbo_en = 1'b1;
    @(posedge clk); @(negedge clk);
    good = 0; armed = 1'b1;
    chk("R11 enable rise unlocks", locked, 0);
    chk("R11 enable rise rearms", turbo_on, 1);

    // code sweep with turbo disabled
    turbo_en = 1'b0;
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 4; c++) begin
        set_sel = s[0];
        code_a = c[1:0];
        code_b = 2'(3 - c);
        @(negedge clk);
        chk("R8 code select", pump_code, s ? c : 3 - c);
        chk("R9 code to current", cp_ua, UA_TAB[s ? c : 3 - c]);
      end

    finish_run();
  end

endmodule